// File: doc/BRIEF.md
# Sleep Entry Power Sequencer

This block is the state machine that takes a device from normal operation down to a clock-gated sleep state, optionally continues to a deeper power state, and brings it back on a wake event. Software or the processor core asks for sleep. The core asks by raising its wait-enable line while its mode field selects sleep. Software asks by writing the control register with the sleep-request bit set. The same write also records whether the deeper state is wanted.

Clocks are not gated straight away. The sequencer first waits until every I/O interface that takes part reports idle. An interface that is disabled, or that is marked as a wake source, is left out of this wait, and a wake source also keeps its clock while the rest of the chip sleeps. If the wait lasts longer than a programmable limit, the sequencer abandons the attempt, returns to run and raises a sticky error flag. Once the interfaces are quiet, the PCI-style bus interface is told to retry all inbound transactions. After it acknowledges, the core clocks stop. The deeper state can only be reached from sleep. When a wake event arrives, the clocks start again and the sequencer waits a fixed settling period before it reports run.

The wait-enable line does not stall the core. Its only visible effect is on three decoded mode outputs: doze, nap and sleep. Every pin is a plain level or strobe control signal. No pin carries a data stream, so the block has no valid/ready handshake.

Top module: `pwr_sleep_seq`

## Requirements
- R1: While reset is asserted and right after it is released, state_o is 6'b000001 (run), core_clk_en is 1, every if_clk_en bit is 1, and pci_retry_req, deep_sleep_o and idle_err are 0.
- R2: state_o always has exactly one bit set. The bits are: bit 0 run, bit 1 idle wait, bit 2 PCI retry, bit 3 sleep, bit 4 deep sleep, bit 5 wake settle.
- R3: doze_o, nap_o and sleep_o equal core_wait_en ANDed with mode_sel equal to 2'b01, 2'b10 and 2'b11 respectively. A mode_sel of 2'b00 raises none of them. Only mode 2'b11 requests sleep, so the other modes leave state_o at run.
- R4: In run, either core_wait_en=1 with mode_sel=2'b11, or csr_wr=1 with csr_sleep_req=1, moves state_o to idle wait on the next clock edge.
- R5: Idle wait moves to PCI retry once every interface i with if_enable[i]=1 and if_wake_src[i]=0 has if_idle[i]=1. The interface bits are: 0 Ethernet, 1 PCI, 2 PCI Express, 3 USB, 4 SATA.
- R6: If the interfaces are still not idle, the state remains idle wait for idle_timeout+1 cycles after it is entered. It then returns to run and sets idle_err.
- R7: idle_err stays set until a cycle in which csr_wr=1 and csr_err_clr=1 both hold. A write with csr_err_clr=0 leaves it set.
- R8: pci_retry_req is 1 in PCI retry, sleep and deep sleep. The PCI retry state moves to sleep when pci_retry_ack=1, or when the PCI interface (bit 1) is disabled.
- R9: core_clk_en is 0 exactly in sleep and deep sleep. Each if_clk_en[i] equals core_clk_en OR if_wake_src[i].
- R10: Every csr_wr captures csr_deep as the deep bit. When this bit is set, sleep moves to deep sleep on the next edge unless a wake event arrives. Deep sleep is entered only from sleep, and deep_sleep_o is 1 exactly in deep sleep.
- R11: wake_evt=1 in sleep or deep sleep moves to wake settle, which turns the clocks on. Wake settle lasts SETTLE_CYCLES (4) cycles and is followed by run.
- R12: wake_evt has no effect in run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| core_wait_en | input | 1 | Core wait-enable level |
| mode_sel | input | 2 | Core power mode select: 01 doze, 10 nap, 11 sleep |
| csr_wr | input | 1 | Control register write strobe |
| csr_sleep_req | input | 1 | Write data: request sleep |
| csr_deep | input | 1 | Write data: deep bit |
| csr_err_clr | input | 1 | Write data: clear idle_err |
| idle_timeout | input | TIMEOUT_W | Idle wait limit in cycles |
| if_enable | input | NUM_IF | Interface takes part in the idle wait |
| if_wake_src | input | NUM_IF | Interface is a wake source |
| if_idle | input | NUM_IF | Interface reports idle |
| pci_retry_ack | input | 1 | PCI interface is now retrying inbound traffic |
| wake_evt | input | 1 | Wake event |
| state_o | output | 6 | One-hot state |
| doze_o | output | 1 | Decoded doze indication |
| nap_o | output | 1 | Decoded nap indication |
| sleep_o | output | 1 | Decoded sleep indication |
| core_clk_en | output | 1 | Core clock enable |
| if_clk_en | output | NUM_IF | Per-interface clock enable |
| pci_retry_req | output | 1 | Tell PCI interface to retry inbound traffic |
| deep_sleep_o | output | 1 | Deep sleep active |
| idle_err | output | 1 | Sticky idle-wait timeout flag |

## Verification
A table of interface mask patterns drives the idle gate. It covers all interfaces quiet, one busy participant, a busy interface excused because it is a wake source, a busy interface excused because it is disabled, a busy PCI interface as the only participant, and two wake sources busy together. Each pattern shows whether the sequencer waits or moves on, which separates the enable mask from the wake mask. Directed runs then follow both request paths through retry, sleep, the optional deep state and wake settle. They also cover a timeout with the sticky flag and its clear, the skipped handshake when PCI is disabled, and a wake pulse given in run.

// File: rtl/pss_pkg.sv
package pss_pkg;
  typedef enum logic [5:0] {
    ST_RUN   = 6'b000001,
    ST_WAIT  = 6'b000010,
    ST_RETRY = 6'b000100,
    ST_SLEEP = 6'b001000,
    ST_DEEP  = 6'b010000,
    ST_WAKE  = 6'b100000
  } pss_state_e;

  localparam int STATE_W = 6;

  typedef enum logic [1:0] {
    MODE_NONE  = 2'b00,
    MODE_DOZE  = 2'b01,
    MODE_NAP   = 2'b10,
    MODE_SLEEP = 2'b11
  } pss_mode_e;

  localparam int IF_ETH  = 0;
  localparam int IF_PCI  = 1;
  localparam int IF_PCIE = 2;
  localparam int IF_USB  = 3;
  localparam int IF_SATA = 4;
endpackage

// File: rtl/pss_idle_gate.sv
module pss_idle_gate #(
  parameter int NUM_IF = 5
) (
  input  logic [NUM_IF-1:0] if_enable,
  input  logic [NUM_IF-1:0] if_wake_src,
  input  logic [NUM_IF-1:0] if_idle,
  output logic              all_quiet
);
  logic [NUM_IF-1:0] lane_ok;

  // A lane is satisfied when it is idle, excused as a wake source, or not taking part
  for (genvar i = 0; i < NUM_IF; i++) begin : g_lane
    assign lane_ok[i] = if_idle[i] | if_wake_src[i] | ~if_enable[i];
  end

  assign all_quiet = &lane_ok;
endmodule

// File: rtl/pss_timer.sv
module pss_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  // Free-running, saturating; restarted on every state change
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (clr)            cnt <= '0;
    else if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/pss_fsm.sv
module pss_fsm
  import pss_pkg::*;
#(
  parameter int CNT_W         = 16,
  parameter int SETTLE_CYCLES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sleep_req,
  input  logic             csr_wr,
  input  logic             csr_deep,
  input  logic             csr_err_clr,
  input  logic             all_quiet,
  input  logic             pci_en,
  input  logic             pci_ack,
  input  logic             wake_evt,
  input  logic [CNT_W-1:0] idle_timeout,
  input  logic [CNT_W-1:0] tmr_cnt,
  output pss_state_e       state,
  output logic             tmr_clr,
  output logic             idle_err
);
  localparam logic [CNT_W-1:0] SETTLE_LAST = CNT_W'(SETTLE_CYCLES - 1);

  pss_state_e nxt;
  logic       deep_bit;
  logic       timed_out;

  always_comb begin
    nxt       = state;
    timed_out = 1'b0;
    unique case (state)
      ST_RUN:   if (sleep_req) nxt = ST_WAIT;
      ST_WAIT: begin
        if (all_quiet) begin
          nxt = ST_RETRY;
        end else if (tmr_cnt >= idle_timeout) begin
          nxt       = ST_RUN;
          timed_out = 1'b1;
        end
      end
      ST_RETRY: if (pci_ack || !pci_en) nxt = ST_SLEEP;
      ST_SLEEP: begin
        if (wake_evt)      nxt = ST_WAKE;
        else if (deep_bit) nxt = ST_DEEP;
      end
      ST_DEEP:  if (wake_evt) nxt = ST_WAKE;
      ST_WAKE:  if (tmr_cnt == SETTLE_LAST) nxt = ST_RUN;
      default:  nxt = ST_RUN;
    endcase
  end

  assign tmr_clr = (nxt != state);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_RUN;
    else        state <= nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      deep_bit <= 1'b0;
    else if (csr_wr) deep_bit <= csr_deep;
  end

  // Setting takes priority over a clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      idle_err <= 1'b0;
    else if (timed_out)              idle_err <= 1'b1;
    else if (csr_wr && csr_err_clr)  idle_err <= 1'b0;
  end
endmodule

// File: rtl/pss_clk_ctrl.sv
module pss_clk_ctrl
  import pss_pkg::*;
#(
  parameter int NUM_IF = 5
) (
  input  pss_state_e        state,
  input  logic [NUM_IF-1:0] if_wake_src,
  output logic              core_clk_en,
  output logic [NUM_IF-1:0] if_clk_en,
  output logic              pci_retry_req,
  output logic              deep_sleep_o
);
  logic gated;

  assign gated         = (state == ST_SLEEP) || (state == ST_DEEP);
  assign core_clk_en   = ~gated;
  assign pci_retry_req = (state == ST_RETRY) || gated;
  assign deep_sleep_o  = (state == ST_DEEP);

  for (genvar i = 0; i < NUM_IF; i++) begin : g_ifclk
    assign if_clk_en[i] = ~gated | if_wake_src[i];
  end
endmodule

// File: rtl/pwr_sleep_seq.sv
module pwr_sleep_seq
  import pss_pkg::*;
#(
  parameter int NUM_IF        = 5,
  parameter int TIMEOUT_W     = 16,
  parameter int SETTLE_CYCLES = 4,
  parameter int PCI_IDX       = IF_PCI
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 core_wait_en,
  input  logic [1:0]           mode_sel,
  input  logic                 csr_wr,
  input  logic                 csr_sleep_req,
  input  logic                 csr_deep,
  input  logic                 csr_err_clr,
  input  logic [TIMEOUT_W-1:0] idle_timeout,
  input  logic [NUM_IF-1:0]    if_enable,
  input  logic [NUM_IF-1:0]    if_wake_src,
  input  logic [NUM_IF-1:0]    if_idle,
  input  logic                 pci_retry_ack,
  input  logic                 wake_evt,
  output logic [5:0]           state_o,
  output logic                 doze_o,
  output logic                 nap_o,
  output logic                 sleep_o,
  output logic                 core_clk_en,
  output logic [NUM_IF-1:0]    if_clk_en,
  output logic                 pci_retry_req,
  output logic                 deep_sleep_o,
  output logic                 idle_err
);
  localparam int CNT_W = TIMEOUT_W;

  pss_state_e       state;
  logic             all_quiet;
  logic             tmr_clr;
  logic [CNT_W-1:0] tmr_cnt;
  logic             sleep_req;

  // Wait-enable only shows up on the decoded mode outputs
  always_comb begin
    doze_o  = core_wait_en && (mode_sel == MODE_DOZE);
    nap_o   = core_wait_en && (mode_sel == MODE_NAP);
    sleep_o = core_wait_en && (mode_sel == MODE_SLEEP);
  end

  assign sleep_req = sleep_o | (csr_wr & csr_sleep_req);
  assign state_o   = state;

  pss_idle_gate #(.NUM_IF(NUM_IF)) u_gate (
    .if_enable   (if_enable),
    .if_wake_src (if_wake_src),
    .if_idle     (if_idle),
    .all_quiet   (all_quiet)
  );

  pss_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (tmr_clr),
    .cnt   (tmr_cnt)
  );

  pss_fsm #(.CNT_W(CNT_W), .SETTLE_CYCLES(SETTLE_CYCLES)) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .sleep_req    (sleep_req),
    .csr_wr       (csr_wr),
    .csr_deep     (csr_deep),
    .csr_err_clr  (csr_err_clr),
    .all_quiet    (all_quiet),
    .pci_en       (if_enable[PCI_IDX]),
    .pci_ack      (pci_retry_ack),
    .wake_evt     (wake_evt),
    .idle_timeout (idle_timeout),
    .tmr_cnt      (tmr_cnt),
    .state        (state),
    .tmr_clr      (tmr_clr),
    .idle_err     (idle_err)
  );

  pss_clk_ctrl #(.NUM_IF(NUM_IF)) u_clk (
    .state         (state),
    .if_wake_src   (if_wake_src),
    .core_clk_en   (core_clk_en),
    .if_clk_en     (if_clk_en),
    .pci_retry_req (pci_retry_req),
    .deep_sleep_o  (deep_sleep_o)
  );
endmodule

// File: rtl/pss_chk.sv
module pss_chk #(
  parameter int NUM_IF = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              core_wait_en,
  input logic [1:0]        mode_sel,
  input logic              csr_wr,
  input logic              csr_sleep_req,
  input logic              csr_err_clr,
  input logic [NUM_IF-1:0] if_enable,
  input logic [NUM_IF-1:0] if_wake_src,
  input logic [NUM_IF-1:0] if_idle,
  input logic              wake_evt,
  input logic [5:0]        state_o,
  input logic              core_clk_en,
  input logic              pci_retry_req,
  input logic              idle_err
);
  // R2
  state_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(state_o) == 1);

  // R9
  clk_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !core_clk_en |-> (state_o[3] || state_o[4]));

  // R8
  retry_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state_o[3] |-> pci_retry_req);

  // R10
  deep_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(state_o[4]) |-> $past(state_o[3]));

  // R5
  idle_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(state_o[2]) |-> $past(&(if_idle | if_wake_src | ~if_enable)));

  // R7
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_err && !(csr_wr && csr_err_clr)) |=> idle_err);

  // R11
  wake_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(state_o[5]) |-> $past(wake_evt));

  // R12
  run_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o[0] && !(core_wait_en && mode_sel == 2'b11) && !(csr_wr && csr_sleep_req))
    |=> state_o[0]);
endmodule

bind pwr_sleep_seq pss_chk #(.NUM_IF(NUM_IF)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .core_wait_en  (core_wait_en),
  .mode_sel      (mode_sel),
  .csr_wr        (csr_wr),
  .csr_sleep_req (csr_sleep_req),
  .csr_err_clr   (csr_err_clr),
  .if_enable     (if_enable),
  .if_wake_src   (if_wake_src),
  .if_idle       (if_idle),
  .wake_evt      (wake_evt),
  .state_o       (state_o),
  .core_clk_en   (core_clk_en),
  .pci_retry_req (pci_retry_req),
  .idle_err      (idle_err)
);

// File: tb/pwr_sleep_seq_tb_top.sv
module pwr_sleep_seq_tb_top;
  localparam logic [5:0] S_RUN = 6'b000001, S_WAIT = 6'b000010, S_RETRY = 6'b000100,
                         S_SLEEP = 6'b001000, S_DEEP = 6'b010000, S_WAKE = 6'b100000;

  // {enable, wake_src, idle, expect_retry}
  localparam logic [15:0] VEC [0:7] = '{
    {5'b11111, 5'b00000, 5'b11111, 1'b1},
    {5'b11111, 5'b00000, 5'b11110, 1'b0},
    {5'b11111, 5'b00001, 5'b11110, 1'b1},
    {5'b11111, 5'b01000, 5'b10111, 1'b1},
    {5'b01111, 5'b00000, 5'b01111, 1'b1},
    {5'b11111, 5'b01001, 5'b10110, 1'b1},
    {5'b11111, 5'b01000, 5'b01111, 1'b0},
    {5'b00010, 5'b00000, 5'b11101, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        core_wait_en = 1'b0;
  logic [1:0]  mode_sel = 2'b00;
  logic        csr_wr = 1'b0, csr_sleep_req = 1'b0, csr_deep = 1'b0, csr_err_clr = 1'b0;
  logic [15:0] idle_timeout = 16'd100;
  logic [4:0]  if_enable = 5'b11111, if_wake_src = 5'b00000, if_idle = 5'b11111;
  logic        pci_retry_ack = 1'b0, wake_evt = 1'b0;
  logic [5:0]  state_o;
  logic        doze_o, nap_o, sleep_o, core_clk_en, pci_retry_req, deep_sleep_o, idle_err;
  logic [4:0]  if_clk_en;

  int n_chk = 0;
  int n_err = 0;

  always #5 clk = ~clk;

  pwr_sleep_seq dut_i (
    .clk(clk), .rst_n(rst_n), .core_wait_en(core_wait_en), .mode_sel(mode_sel),
    .csr_wr(csr_wr), .csr_sleep_req(csr_sleep_req), .csr_deep(csr_deep),
    .csr_err_clr(csr_err_clr), .idle_timeout(idle_timeout), .if_enable(if_enable),
    .if_wake_src(if_wake_src), .if_idle(if_idle), .pci_retry_ack(pci_retry_ack),
    .wake_evt(wake_evt), .state_o(state_o), .doze_o(doze_o), .nap_o(nap_o),
    .sleep_o(sleep_o), .core_clk_en(core_clk_en), .if_clk_en(if_clk_en),
    .pci_retry_req(pci_retry_req), .deep_sleep_o(deep_sleep_o), .idle_err(idle_err)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    step(2);
    rst_n = 1'b1;
  endtask

  task automatic csr_request(input logic deep);
    csr_wr = 1'b1; csr_sleep_req = 1'b1; csr_deep = deep;
    step(1);
    csr_wr = 1'b0; csr_sleep_req = 1'b0; csr_deep = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    step(1);
    // R1 reset values
    chk("R1 state in reset", 32'(state_o), 32'(S_RUN));
    do_reset();
    chk("R1 state", 32'(state_o), 32'(S_RUN));
    chk("R1 core_clk_en", 32'(core_clk_en), 32'd1);
    chk("R1 if_clk_en", 32'(if_clk_en), 32'h1f);
    chk("R1 retry", 32'(pci_retry_req), 32'd0);
    chk("R1 deep", 32'(deep_sleep_o), 32'd0);
    chk("R1 err", 32'(idle_err), 32'd0);

    // R5 idle gate patterns
    foreach (VEC[k]) begin
      do_reset();
      if_enable = VEC[k][15:11]; if_wake_src = VEC[k][10:6]; if_idle = VEC[k][5:1];
      csr_request(1'b0);
      step(2);
      chk($sformatf("R5 vector %0d", k), 32'(state_o),
          VEC[k][0] ? 32'(S_RETRY) : 32'(S_WAIT));
    end

    // R3 mode decode
    do_reset();
    if_enable = 5'b11111; if_wake_src = 5'b00000; if_idle = 5'b11111;
    core_wait_en = 1'b1; mode_sel = 2'b01; #1;
    chk("R3 doze", 32'({doze_o, nap_o, sleep_o}), 32'b100);
    step(1);
    chk("R3 doze no sleep", 32'(state_o), 32'(S_RUN));
    mode_sel = 2'b10; #1;
    chk("R3 nap", 32'({doze_o, nap_o, sleep_o}), 32'b010);
    mode_sel = 2'b00; #1;
    chk("R3 none", 32'({doze_o, nap_o, sleep_o}), 32'b000);
    core_wait_en = 1'b0; mode_sel = 2'b11; #1;
    chk("R3 no wait", 32'({doze_o, nap_o, sleep_o}), 32'b000);
    step(1);
    chk("R3 no wait state", 32'(state_o), 32'(S_RUN));

    // R4 core request, R8 handshake, R9 gating, R11 wake
    if_wake_src = 5'b01000;
    core_wait_en = 1'b1;
    step(1);
    core_wait_en = 1'b0;
    chk("R4 core request", 32'(state_o), 32'(S_WAIT));
    step(1);
    chk("R8 retry state", 32'(state_o), 32'(S_RETRY));
    chk("R8 retry req", 32'(pci_retry_req), 32'd1);
    chk("R9 clk on in retry", 32'(core_clk_en), 32'd1);
    pci_retry_ack = 1'b1;
    step(1);
    pci_retry_ack = 1'b0;
    chk("R8 sleep after ack", 32'(state_o), 32'(S_SLEEP));
    chk("R9 core gated", 32'(core_clk_en), 32'd0);
    chk("R9 wake src clock", 32'(if_clk_en), 32'b01000);
    chk("R8 retry held", 32'(pci_retry_req), 32'd1);
    step(3);
    chk("R10 no deep bit", 32'(state_o), 32'(S_SLEEP));
    wake_evt = 1'b1;
    step(1);
    wake_evt = 1'b0;
    chk("R11 wake state", 32'(state_o), 32'(S_WAKE));
    chk("R11 clk on", 32'(core_clk_en), 32'd1);
    step(3);
    chk("R11 settle 4th", 32'(state_o), 32'(S_WAKE));
    step(1);
    chk("R11 back to run", 32'(state_o), 32'(S_RUN));

    // R12 wake in run ignored
    wake_evt = 1'b1;
    step(1);
    wake_evt = 1'b0;
    chk("R12 wake in run", 32'(state_o), 32'(S_RUN));
    chk("R12 clk", 32'(core_clk_en), 32'd1);

    // R6 timeout, R7 sticky
    do_reset();
    if_wake_src = 5'b00000; if_idle = 5'b11110; idle_timeout = 16'd5;
    csr_request(1'b0);
    step(5);
    chk("R6 still waiting", 32'(state_o), 32'(S_WAIT));
    chk("R6 no err yet", 32'(idle_err), 32'd0);
    step(1);
    chk("R6 timeout run", 32'(state_o), 32'(S_RUN));
    chk("R6 err set", 32'(idle_err), 32'd1);
    csr_wr = 1'b1;
    step(1);
    csr_wr = 1'b0;
    chk("R7 err kept", 32'(idle_err), 32'd1);
    csr_wr = 1'b1; csr_err_clr = 1'b1;
    step(1);
    csr_wr = 1'b0; csr_err_clr = 1'b0;
    chk("R7 err cleared", 32'(idle_err), 32'd0);

    // R10 deep path
    do_reset();
    if_idle = 5'b11111; idle_timeout = 16'd100; pci_retry_ack = 1'b1;
    csr_request(1'b1);
    step(2);
    chk("R10 via sleep", 32'(state_o), 32'(S_SLEEP));
    step(1);
    chk("R10 deep", 32'(state_o), 32'(S_DEEP));
    chk("R10 deep out", 32'(deep_sleep_o), 32'd1);
    chk("R9 all gated", 32'(if_clk_en), 32'd0);
    pci_retry_ack = 1'b0;
    wake_evt = 1'b1;
    step(1);
    wake_evt = 1'b0;
    chk("R11 wake from deep", 32'(state_o), 32'(S_WAKE));
    chk("R10 deep off", 32'(deep_sleep_o), 32'd0);
    step(4);
    chk("R11 run after deep", 32'(state_o), 32'(S_RUN));

    // R8 PCI disabled skips handshake
    do_reset();
    if_enable = 5'b11101;
    csr_request(1'b0);
    step(2);
    chk("R8 pci disabled", 32'(state_o), 32'(S_SLEEP));

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule